// File: doc/BRIEF.md
# Tiled Matrix-Multiply Loop Sequencer

This block runs a matrix product C[M×K] = A[M×N] × B[N×K] on a fixed square systolic array that is smaller than the matrices. It splits the job into tiles and walks three nested loops over them. For each tile step it issues one command on a single command port and waits for that command's done handshake before it issues the next. The commands are: clear the output accumulator, load an A tile, load a B tile, run the array, and store a C tile. Each command carries an address computed from a base address and the tile position. The DMA engines, the array and any local memory sit outside the block.

Software gives the three dimensions, a tile configuration word and three base addresses, then pulses `start`. The block copies all of these inputs when it starts. It keeps `busy` high while the job runs and counts the array runs. After the last C tile has been stored it raises `done` for one cycle.

Top module: `tile_seq`

## Requirements
- R1: While reset is held and right after it, `busy`, `cmd_valid` and `done` are 0 and `run_count` is 0.
- R2: The tile configuration word gives the row tile height TM in bits 15:0 and the tile width TN in bits 31:16. The outermost loop steps the row index mi over M in steps of TM. The middle loop steps the column index ki over K in steps of TN. The innermost loop steps ni over N in steps of TN.
- R3: For each output tile the command order is fixed. First comes one clear (op 0). Then, for each inner step, load A (op 1), load B (op 2) and run (op 3). Last comes one store (op 4), after the final inner step.
- R4: The address of a load-A command is base_a + mi×N + ni (1-byte elements, row stride N).
- R5: The address of a load-B command is base_b + ni×K + ki (1-byte elements, row stride K).
- R6: The clear and store commands carry base_c + 4×(mi×K + ki) (4-byte elements, row stride K). A run command carries address 0.
- R7: Once `cmd_valid` is raised, it stays high, and `cmd_op` and `cmd_addr` stay unchanged, until the first cycle in which `cmd_done` is high. The next command appears in the following cycle.
- R8: `cmd_done` has no effect while no command is pending. `start` has no effect while `busy` is high.
- R9: `run_count` is cleared on an accepted start and then counts accepted run commands. At the end of a job it equals (M/TM)×(N/TN)×(K/TN).
- R10: `done` is high for exactly one cycle, in the cycle after the last store is accepted. `busy` and `cmd_valid` are low in that cycle.
- R11: A start with M, N, K, TM or TN equal to zero issues no command. It gives `done` in the next cycle, with `run_count` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse, accepted only while idle |
| dim_m | input | 16 | Rows of A and C |
| dim_n | input | 16 | Shared dimension |
| dim_k | input | 16 | Columns of B and C |
| tile_cfg | input | 32 | TM in bits 15:0, TN in bits 31:16 |
| base_a | input | 32 | Byte base address of A |
| base_b | input | 32 | Byte base address of B |
| base_c | input | 32 | Byte base address of C |
| cmd_valid | output | 1 | A command is pending |
| cmd_op | output | 3 | 0 clear, 1 load A, 2 load B, 3 run, 4 store C |
| cmd_addr | output | 32 | Tile address of the pending command |
| cmd_done | input | 1 | Completion of the pending command |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| run_count | output | 32 | Array runs in the current or last job |

## Verification
The assertions check, on every cycle, the parts that are local in time. A pending command stays stable until it is acknowledged. A clear is followed by a load A, and a load B is followed by a run. Each accepted run adds one to the count. The end pulse never coincides with a pending command, and an idle block stays idle without a start. Only the bench scenarios can show the whole-job properties. These are the full command and address sequence for several shapes, including unequal TM and TN, and the final count. They also cover the zero-dimension shortcut and the fact that a second start in the middle of a job leaves that job's sequence unchanged.

// File: rtl/tile_seq.sv
module tile_seq #(
  parameter int DW = 16,
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dim_m,
  input  logic [DW-1:0] dim_n,
  input  logic [DW-1:0] dim_k,
  input  logic [2*DW-1:0] tile_cfg,
  input  logic [AW-1:0] base_a,
  input  logic [AW-1:0] base_b,
  input  logic [AW-1:0] base_c,
  output logic          cmd_valid,
  output logic [2:0]    cmd_op,
  output logic [AW-1:0] cmd_addr,
  input  logic          cmd_done,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] run_count
);
  typedef enum logic [2:0] {
    S_CLR = 3'd0, S_LDA = 3'd1, S_LDB = 3'd2, S_RUN = 3'd3, S_STC = 3'd4, S_IDLE = 3'd7
  } st_t;

  st_t st;
  logic [DW-1:0] m_r, n_r, k_r, tm_r, tn_r, mi, ki, ni;
  logic [AW-1:0] ba_r, bb_r, bc_r;

  function automatic logic [AW-1:0] zx(input logic [DW-1:0] v);
    return AW'(v);
  endfunction

  wire [AW-1:0] a_addr = ba_r + zx(mi) * zx(n_r) + zx(ni);
  wire [AW-1:0] b_addr = bb_r + zx(ni) * zx(k_r) + zx(ki);
  wire [AW-1:0] c_addr = bc_r + ((zx(mi) * zx(k_r) + zx(ki)) << 2);

  wire ni_last = ({1'b0, ni} + {1'b0, tn_r}) >= {1'b0, n_r};
  wire ki_last = ({1'b0, ki} + {1'b0, tn_r}) >= {1'b0, k_r};
  wire mi_last = ({1'b0, mi} + {1'b0, tm_r}) >= {1'b0, m_r};
  wire empty_job = (dim_m == '0) || (dim_n == '0) || (dim_k == '0) ||
                   (tile_cfg[DW-1:0] == '0) || (tile_cfg[2*DW-1:DW] == '0);

  assign busy      = (st != S_IDLE);
  assign cmd_valid = busy;
  assign cmd_op    = st;

  always_comb begin
    case (st)
      S_LDA:        cmd_addr = a_addr;
      S_LDB:        cmd_addr = b_addr;
      S_CLR, S_STC: cmd_addr = c_addr;
      default:      cmd_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      done <= 1'b0;
      run_count <= '0;
      {m_r, n_r, k_r, tm_r, tn_r, mi, ki, ni} <= '0;
      {ba_r, bb_r, bc_r} <= '0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          m_r <= dim_m; n_r <= dim_n; k_r <= dim_k;
          tm_r <= tile_cfg[DW-1:0]; tn_r <= tile_cfg[2*DW-1:DW];
          ba_r <= base_a; bb_r <= base_b; bc_r <= base_c;
          mi <= '0; ki <= '0; ni <= '0;
          run_count <= '0;
          if (empty_job) done <= 1'b1;
          else st <= S_CLR;
        end
      end else if (cmd_done) begin
        case (st)
          S_CLR: st <= S_LDA;
          S_LDA: st <= S_LDB;
          S_LDB: st <= S_RUN;
          S_RUN: begin
            run_count <= run_count + 1'b1;
            if (ni_last) st <= S_STC;
            else begin ni <= ni + tn_r; st <= S_LDA; end
          end
          S_STC: begin
            ni <= '0;
            if (!ki_last) begin ki <= ki + tn_r; st <= S_CLR; end
            else begin
              ki <= '0;
              if (mi_last) begin st <= S_IDLE; done <= 1'b1; end
              else begin mi <= mi + tm_r; st <= S_CLR; end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_addr))); // R7
  AST_CLR_THEN_LDA: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_done && cmd_op == 3'd0) |=> (cmd_valid && cmd_op == 3'd1)); // R3
  AST_LDB_THEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_done && cmd_op == 3'd2) |=> (cmd_valid && cmd_op == 3'd3)); // R3
  AST_RUN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_done && cmd_op == 3'd3) |=> (run_count == $past(run_count) + 1'b1)); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !cmd_valid)); // R10
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy); // R8
endmodule

// File: tb/tile_seq_test.sv
module tile_seq_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, cmd_done, cmd_valid, busy, done;
  logic [15:0] dim_m, dim_n, dim_k;
  logic [31:0] tile_cfg, base_a, base_b, base_c, cmd_addr, run_count;
  logic [2:0] cmd_op;

  tile_seq uut (.clk(clk), .rst_n(rst_n), .start(start), .dim_m(dim_m), .dim_n(dim_n),
    .dim_k(dim_k), .tile_cfg(tile_cfg), .base_a(base_a), .base_b(base_b), .base_c(base_c),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_done(cmd_done),
    .busy(busy), .done(done), .run_count(run_count));

  int errors = 0, checks = 0;
  logic [34:0] expq[$];
  bit resp_on = 0;
  int lat = 0, wait_cnt = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] op, input logic [31:0] addr);
    expq.push_back({op, addr});
  endtask

  // R2 R3 R4 R5 R6: expected command stream
  task automatic plan(input int m, input int n, input int k, input int tm, input int tn,
                      input logic [31:0] ba, input logic [31:0] bb, input logic [31:0] bc);
    for (int mi = 0; mi < m; mi += tm)
      for (int ki = 0; ki < k; ki += tn) begin
        push(3'd0, bc + 32'((mi * k + ki) * 4));
        for (int ni = 0; ni < n; ni += tn) begin
          push(3'd1, ba + 32'(mi * n + ni));
          push(3'd2, bb + 32'(ni * k + ki));
          push(3'd3, 32'd0);
        end
        push(3'd4, bc + 32'((mi * k + ki) * 4));
      end
  endtask

  // monitor / responder: compares each command, then acknowledges it (R7)
  initial begin
    cmd_done = 1'b0;
    forever begin
      @(negedge clk);
      if (resp_on) begin
        if (cmd_done) cmd_done = 1'b0;
        else if (cmd_valid) begin
          if (wait_cnt == 0) begin
            if (expq.size() == 0) check(0, "R3 unexpected command", {29'd0, cmd_op, cmd_addr}, 0);
            else begin
              logic [34:0] e;
              e = expq.pop_front();
              check({cmd_op, cmd_addr} === e, "R3 R4 R5 R6 command", {29'd0, cmd_op, cmd_addr}, {29'd0, e});
            end
            cmd_done = 1'b1;
            wait_cnt = lat;
          end else wait_cnt--;
        end
      end
    end
  end

  task automatic run_job(input int m, input int n, input int k, input int tm, input int tn,
                         input int l, input bit restart_mid);
    int guard;
    dim_m = 16'(m); dim_n = 16'(n); dim_k = 16'(k);
    tile_cfg = {16'(tn), 16'(tm)};
    base_a = 32'h1000_0000 + 32'(m); base_b = 32'h2000_0100; base_c = 32'h3000_0040;
    plan(m, n, k, tm, tn, base_a, base_b, base_c);
    lat = l; wait_cnt = l; resp_on = 1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (restart_mid) begin
      repeat (5) @(negedge clk);
      start = 1'b1; // R8: ignored while busy
      dim_m = 16'd2; tile_cfg = 32'h0001_0001;
      @(negedge clk) start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 20000) begin @(negedge clk); guard++; end
    check(done === 1'b1, "R10 done seen", done, 1);
    check(run_count == 32'((m / tm) * (n / tn) * (k / tn)), "R9 run count", run_count, (m / tm) * (n / tn) * (k / tn));
    check(expq.size() == 0, "R3 commands left", expq.size(), 0);
    check(!busy && !cmd_valid, "R10 idle with done", {busy, cmd_valid}, 0);
    @(negedge clk);
    check(done === 1'b0, "R10 single cycle", done, 0);
    resp_on = 0;
    expq.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    dim_m = '0; dim_n = '0; dim_k = '0; tile_cfg = '0;
    base_a = '0; base_b = '0; base_c = '0;
    repeat (3) @(negedge clk);
    // R1
    check(!busy && !cmd_valid && !done, "R1 reset outputs", {busy, cmd_valid, done}, 0);
    check(run_count == 0, "R1 reset count", run_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !cmd_valid && !done, "R1 after reset", {busy, cmd_valid, done}, 0);
    // R8: stray cmd_done while idle
    cmd_done = 1'b1;
    @(negedge clk) cmd_done = 1'b0;
    @(negedge clk);
    check(!busy && !cmd_valid, "R8 stray done ignored", {busy, cmd_valid}, 0);
    run_job(4, 4, 4, 4, 4, 0, 0);     // R3 single tile
    run_job(8, 8, 8, 4, 4, 0, 0);     // R2 square tiling
    run_job(4, 12, 8, 2, 4, 2, 0);    // R2 TM differs from TN, slow acks (R7)
    run_job(6, 8, 4, 3, 2, 1, 1);     // R8 restart while busy
    // R11: zero dimension
    dim_m = 16'd8; dim_n = 16'd8; dim_k = 16'd0; tile_cfg = 32'h0004_0004;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(done === 1'b1 && !cmd_valid, "R11 zero job done", {done, cmd_valid}, 2);
    check(run_count == 0, "R11 zero job count", run_count, 0);
    @(negedge clk);
    check(!done && !busy, "R11 back to idle", {done, busy}, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule